// File: doc/BRIEF.md
# Host Port Packing Buffer with Interrupt

This block sits between a host data port and a processor core for single-word transfers that bypass DMA. When the host writes, narrow host words are collected and assembled into wide core words that the core then reads. When the host reads, the core writes wide words and the block hands them back to the host as a series of narrow words. Three width pairings can be selected. A control register sets the pairing, the transfer direction, the enables and a self-clearing flush. A dedicated flow-control signal on each side shows when that side may write.

When interrupt-driven I/O is selected and DMA is off, the block raises a request in two cases. With the host writing, it fires when assembled data waits for the core. With the host reading, it fires when the core has to supply the next word. The request is caught by a sticky latch that software clears. The output pin is that latch gated by a mask, so a request that arrived while masked stays visible in the latch until it is cleared.

Top module: `host_pack_buf`

## Requirements
- R1: After reset the control readback is 0, no side reports valid data or write readiness, and `irq_pend` and `irq` are 0.
- R2: Control word layout: bit 0 enable, bit 1 flush, bits 3:2 width mode (00 = 16-to-32, 01 = 16-to-48, 10 = 32-to-48), bit 4 direction (1 = host reads, 0 = host writes), bit 5 DMA enable, bit 6 interrupt-I/O enable. The readback returns the stored fields in the same positions, and bit 1 always reads 0.
- R3: A control write with bit 1 set empties the buffer and drops any partly assembled group. The status outputs still show the old state during the write cycle and show an empty buffer from the next cycle on.
- R4: A control write with bit 0 and bit 1 both set flushes, leaves the block disabled, and pulses `ctrl_err` high for exactly the following cycle.
- R5: In mode 00 with direction 0, two host writes (low 16 bits each, first word least significant) yield one core word {16'b0, w1[15:0], w0[15:0]}.
- R6: In mode 01 with direction 0, three host writes yield {w2[15:0], w1[15:0], w0[15:0]}.
- R7: In mode 10 with direction 0, three 32-bit host writes yield two core words: first {w2,w1,w0}[47:0], then {w2,w1,w0}[95:48]. Assembly restarts after each third host word.
- R8: With direction 1, core words are split into host words lowest bits first: 16-bit pieces, zero-extended to 32 bits, in modes 00 (two per core word) and 01 (three per core word); in mode 10, two core words c0 then c1 give the three 32-bit words of {c1,c0}.
- R9: The filling side is ready only when the block is enabled, the direction selects it, and no assembled word remains undrained. A write while not ready has no effect.
- R10: The request is enable AND NOT DMA-enable AND interrupt-I/O-enable AND (direction ? `core_wready` : `core_rvalid`). `irq_pend` sets one cycle after the request rises, whatever the mask.
- R11: `irq` equals `irq_pend` AND `irq_mask`. A pulse on `irq_clr` clears `irq_pend` on the next edge unless a new rising request sets it on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 7 | Control word written |
| ctrl_rdata | output | 7 | Control readback, flush bit always 0 |
| ctrl_err | output | 1 | One-cycle pulse after an illegal enable-with-flush write |
| host_wr | input | 1 | Host word write strobe |
| host_wdata | input | 32 | Host word in; low 16 bits used in modes 00 and 01 |
| host_wready | output | 1 | Host may write |
| host_rd | input | 1 | Host pops the current word |
| host_rdata | output | 32 | Current host word out |
| host_rvalid | output | 1 | Host word available |
| core_wr | input | 1 | Core word write strobe |
| core_wdata | input | 48 | Core word in |
| core_wready | output | 1 | Core may write |
| core_rd | input | 1 | Core pops the current word |
| core_rdata | output | 48 | Current core word out |
| core_rvalid | output | 1 | Core word available |
| irq_mask | input | 1 | Interrupt mask, 1 = pass |
| irq_clr | input | 1 | Clear pulse for the request latch |
| irq_pend | output | 1 | Request latch |
| irq | output | 1 | Masked interrupt request |

## Verification
Two cases can land in one cycle. The first is a flush together with a data write into a half-filled group. The second is a flush together with a set enable in the same control word. The bench drives a control write carrying both flush and enable, and checks that flush wins, that the stored enable is clear, and that the error pulse appears one cycle later. It also holds a flush strobe while the buffer is full and confirms that the status is unchanged within that cycle and empty after the edge. The flush is followed by a fresh two-word group, and the bench confirms the assembled word holds none of the discarded half.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

  typedef enum logic [1:0] {
    PK_16_32 = 2'b00,
    PK_16_48 = 2'b01,
    PK_32_48 = 2'b10,
    PK_RSVD  = 2'b11
  } pk_mode_e;

  typedef struct packed {
    logic     intio;
    logic     dma_en;
    logic     dir;
    pk_mode_e mode;
    logic     en;
  } ctrl_t;

  // slots written by the filling side before a group completes
  function automatic logic [1:0] fill_per_group(pk_mode_e mode, logic dir);
    if (dir) return (mode == PK_32_48) ? 2'd2 : 2'd1;
    return (mode == PK_16_48 || mode == PK_32_48) ? 2'd3 : 2'd2;
  endfunction

  // slots the draining side pops per completed group
  function automatic logic [1:0] drain_per_group(pk_mode_e mode, logic dir);
    if (!dir) return (mode == PK_32_48) ? 2'd2 : 2'd1;
    return (mode == PK_16_48 || mode == PK_32_48) ? 2'd3 : 2'd2;
  endfunction

endpackage

// File: rtl/hpb_ctrl.sv
module hpb_ctrl
  import hpb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [6:0] ctrl_wdata,
  output logic [6:0] ctrl_rdata,
  output logic       ctrl_err,
  output logic       flush,
  output logic       cfg_en,
  output pk_mode_e   cfg_mode,
  output logic       cfg_dir,
  output logic       cfg_dma,
  output logic       cfg_intio
);

  ctrl_t cfg_q, cfg_d;
  logic  err_q, err_d;

  always_comb begin
    cfg_d = cfg_q;
    if (ctrl_wr) begin
      cfg_d.en     = ctrl_wdata[0] & ~ctrl_wdata[1];
      cfg_d.mode   = pk_mode_e'(ctrl_wdata[3:2]);
      cfg_d.dir    = ctrl_wdata[4];
      cfg_d.dma_en = ctrl_wdata[5];
      cfg_d.intio  = ctrl_wdata[6];
    end
    err_d = ctrl_wr & ctrl_wdata[0] & ctrl_wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (ctrl_wr) cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign flush      = ctrl_wr & ctrl_wdata[1];
  assign ctrl_err   = err_q;
  assign cfg_en     = cfg_q.en;
  assign cfg_mode   = cfg_q.mode;
  assign cfg_dir    = cfg_q.dir;
  assign cfg_dma    = cfg_q.dma_en;
  assign cfg_intio  = cfg_q.intio;
  assign ctrl_rdata = {cfg_q.intio, cfg_q.dma_en, cfg_q.dir, cfg_q.mode, 1'b0, cfg_q.en};

  // R4
  en_flush_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata[0] && ctrl_wdata[1]) |=> (ctrl_err && !cfg_en));

endmodule

// File: rtl/hpb_pack.sv
module hpb_pack
  import hpb_pkg::*;
#(
  parameter int NW = 16,
  parameter int HW = 32,
  parameter int CW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          en,
  input  pk_mode_e      mode,
  input  logic          dir,
  input  logic          host_wr,
  input  logic [HW-1:0] host_wdata,
  output logic          host_wready,
  input  logic          host_rd,
  output logic [HW-1:0] host_rdata,
  output logic          host_rvalid,
  input  logic          core_wr,
  input  logic [CW-1:0] core_wdata,
  output logic          core_wready,
  input  logic          core_rd,
  output logic [CW-1:0] core_rdata,
  output logic          core_rvalid
);

  localparam int BW = 2 * CW;

  logic [BW-1:0] stg_q, stg_d;
  logic [1:0]    fill_q, fill_d, avail_q, avail_d, ridx_q, ridx_d, fill_nx;
  logic          wide, fill_rdy, fill_do, drain_do, stg_en;

  assign wide     = (mode == PK_32_48);
  assign fill_rdy = en && (avail_q == 2'd0);
  assign fill_do  = fill_rdy && (dir ? core_wr : host_wr);
  assign drain_do = (avail_q != 2'd0) && (dir ? host_rd : core_rd);
  assign fill_nx  = fill_q + 2'd1;
  assign stg_en   = fill_do && !flush;

  always_comb begin
    stg_d = stg_q;
    if (dir)       stg_d[int'(fill_q)*CW +: CW] = core_wdata;
    else if (wide) stg_d[int'(fill_q)*HW +: HW] = host_wdata;
    else           stg_d[int'(fill_q)*NW +: NW] = host_wdata[NW-1:0];
  end

  always_comb begin
    fill_d  = fill_q;
    avail_d = avail_q;
    ridx_d  = ridx_q;
    if (flush) begin
      fill_d  = 2'd0;
      avail_d = 2'd0;
      ridx_d  = 2'd0;
    end else if (fill_do) begin
      if (fill_nx == fill_per_group(mode, dir)) begin
        fill_d  = 2'd0;
        avail_d = drain_per_group(mode, dir);
        ridx_d  = 2'd0;
      end else begin
        fill_d = fill_nx;
      end
    end else if (drain_do) begin
      avail_d = avail_q - 2'd1;
      ridx_d  = ridx_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q   <= '0;
      fill_q  <= 2'd0;
      avail_q <= 2'd0;
      ridx_q  <= 2'd0;
    end else begin
      if (stg_en) stg_q <= stg_d;
      fill_q  <= fill_d;
      avail_q <= avail_d;
      ridx_q  <= ridx_d;
    end
  end

  assign host_wready = fill_rdy && !dir;
  assign core_wready = fill_rdy && dir;
  assign host_rvalid = dir && (avail_q != 2'd0);
  assign core_rvalid = !dir && (avail_q != 2'd0);

  always_comb begin
    if (wide) host_rdata = stg_q[int'(ridx_q)*HW +: HW];
    else      host_rdata = {{(HW-NW){1'b0}}, stg_q[int'(ridx_q)*NW +: NW]};
    if (mode == PK_16_48 || wide) core_rdata = stg_q[int'(ridx_q)*CW +: CW];
    else                          core_rdata = {{(CW-2*NW){1'b0}}, stg_q[2*NW-1:0]};
  end

  // R3
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!host_rvalid && !core_rvalid && fill_q == 2'd0));

  // R9
  no_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_q != 2'd0 && !flush) |=> (avail_q <= $past(avail_q)));

  // R9
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= 2'd2);

endmodule

// File: rtl/hpb_irq.sv
module hpb_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dma,
  input  logic intio,
  input  logic dir,
  input  logic core_rvalid,
  input  logic core_wready,
  input  logic irq_mask,
  input  logic irq_clr,
  output logic irq_pend,
  output logic irq
);

  logic req, req_q, rise, pend_q, pend_d;

  assign req    = en && !dma && intio && (dir ? core_wready : core_rvalid);
  assign rise   = req && !req_q;
  assign pend_d = rise || (pend_q && !irq_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= req;
      pend_q <= pend_d;
    end
  end

  assign irq_pend = pend_q;
  assign irq      = pend_q & irq_mask;

  // R10
  set_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !req_q) |=> irq_pend);

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !(req && !req_q)) |=> !irq_pend);

endmodule

// File: rtl/host_pack_buf.sv
module host_pack_buf
  import hpb_pkg::*;
#(
  parameter int NW = 16,
  parameter int HW = 32,
  parameter int CW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [6:0]    ctrl_wdata,
  output logic [6:0]    ctrl_rdata,
  output logic          ctrl_err,
  input  logic          host_wr,
  input  logic [HW-1:0] host_wdata,
  output logic          host_wready,
  input  logic          host_rd,
  output logic [HW-1:0] host_rdata,
  output logic          host_rvalid,
  input  logic          core_wr,
  input  logic [CW-1:0] core_wdata,
  output logic          core_wready,
  input  logic          core_rd,
  output logic [CW-1:0] core_rdata,
  output logic          core_rvalid,
  input  logic          irq_mask,
  input  logic          irq_clr,
  output logic          irq_pend,
  output logic          irq
);

  logic [1:0] rs_q;
  logic       srst_n, flush, en, dir, dma, intio;
  pk_mode_e   mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  hpb_ctrl u_ctrl (
    .clk(clk), .rst_n(srst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .ctrl_err(ctrl_err), .flush(flush),
    .cfg_en(en), .cfg_mode(mode), .cfg_dir(dir), .cfg_dma(dma), .cfg_intio(intio)
  );

  hpb_pack #(.NW(NW), .HW(HW), .CW(CW)) u_pack (
    .clk(clk), .rst_n(srst_n), .flush(flush), .en(en), .mode(mode), .dir(dir),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_wready(host_wready),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .core_wr(core_wr), .core_wdata(core_wdata), .core_wready(core_wready),
    .core_rd(core_rd), .core_rdata(core_rdata), .core_rvalid(core_rvalid)
  );

  hpb_irq u_irq (
    .clk(clk), .rst_n(srst_n), .en(en), .dma(dma), .intio(intio), .dir(dir),
    .core_rvalid(core_rvalid), .core_wready(core_wready),
    .irq_mask(irq_mask), .irq_clr(irq_clr), .irq_pend(irq_pend), .irq(irq)
  );

endmodule

// File: tb/host_pack_buf_bench.sv
`timescale 1ns/100ps
module host_pack_buf_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [6:0]  ctrl_wdata = '0;
  logic [6:0]  ctrl_rdata;
  logic        ctrl_err;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        host_wready;
  logic        host_rd = 1'b0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        core_wr = 1'b0;
  logic [47:0] core_wdata = '0;
  logic        core_wready;
  logic        core_rd = 1'b0;
  logic [47:0] core_rdata;
  logic        core_rvalid;
  logic        irq_mask = 1'b0;
  logic        irq_clr = 1'b0;
  logic        irq_pend;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  host_pack_buf u_host_pack_buf (.*);

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_en, m_dir, m_dma, m_intio, m_err, m_reqq, m_pend;
  bit [1:0]    m_mode;
  logic [31:0] hin[$];
  logic [31:0] hout[$];
  logic [47:0] cin[$];
  logic [47:0] cout[$];

  function automatic bit e_hwr();  return m_en && !m_dir && cout.size() == 0; endfunction
  function automatic bit e_cwr();  return m_en && m_dir && hout.size() == 0;  endfunction
  function automatic bit e_hrv();  return m_dir && hout.size() != 0;          endfunction
  function automatic bit e_crv();  return !m_dir && cout.size() != 0;         endfunction
  function automatic bit e_req();
    return m_en && !m_dma && m_intio && (m_dir ? e_cwr() : e_crv());
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit req, hw_ok, cw_ok, hr_ok, cr_ok;
    logic [95:0] t;
    if (!rst_n) begin
      m_en = 0; m_dir = 0; m_dma = 0; m_intio = 0; m_err = 0; m_reqq = 0; m_pend = 0;
      m_mode = 0;
      hin.delete(); hout.delete(); cin.delete(); cout.delete();
    end else begin
      req = e_req(); hw_ok = e_hwr(); cw_ok = e_cwr(); hr_ok = e_hrv(); cr_ok = e_crv();
      if (ctrl_wr && ctrl_wdata[1]) begin
        hin.delete(); hout.delete(); cin.delete(); cout.delete();
      end else begin
        if (host_wr && hw_ok) begin
          hin.push_back(host_wdata);
          if (hin.size() == ((m_mode == 2'b01 || m_mode == 2'b10) ? 3 : 2)) begin
            if (m_mode == 2'b10) begin
              t = {hin[2], hin[1], hin[0]};
              cout.push_back(t[47:0]);
              cout.push_back(t[95:48]);
            end else if (m_mode == 2'b01)
              cout.push_back({hin[2][15:0], hin[1][15:0], hin[0][15:0]});
            else
              cout.push_back({16'h0, hin[1][15:0], hin[0][15:0]});
            hin.delete();
          end
        end
        if (core_rd && cr_ok) void'(cout.pop_front());
        if (core_wr && cw_ok) begin
          cin.push_back(core_wdata);
          if (cin.size() == ((m_mode == 2'b10) ? 2 : 1)) begin
            if (m_mode == 2'b10) begin
              t = {cin[1], cin[0]};
              hout.push_back(t[31:0]);
              hout.push_back(t[63:32]);
              hout.push_back(t[95:64]);
            end else begin
              hout.push_back({16'h0, cin[0][15:0]});
              hout.push_back({16'h0, cin[0][31:16]});
              if (m_mode == 2'b01) hout.push_back({16'h0, cin[0][47:32]});
            end
            cin.delete();
          end
        end
        if (host_rd && hr_ok) void'(hout.pop_front());
      end
      m_pend = (req && !m_reqq) || (m_pend && !irq_clr);
      m_reqq = req;
      m_err  = ctrl_wr && ctrl_wdata[0] && ctrl_wdata[1];
      if (ctrl_wr) begin
        m_en = ctrl_wdata[0] && !ctrl_wdata[1];
        m_mode = ctrl_wdata[3:2]; m_dir = ctrl_wdata[4];
        m_dma = ctrl_wdata[5]; m_intio = ctrl_wdata[6];
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model ctrl_rdata", ctrl_rdata, {m_intio, m_dma, m_dir, m_mode, 1'b0, m_en});
      chk("R4 model ctrl_err", ctrl_err, m_err);
      chk("R9 model host_wready", host_wready, e_hwr());
      chk("R9 model core_wready", core_wready, e_cwr());
      chk("R8 model host_rvalid", host_rvalid, e_hrv());
      chk("R5 model core_rvalid", core_rvalid, e_crv());
      if (e_hrv()) chk("R8 model host_rdata", host_rdata, hout[0]);
      if (e_crv()) chk("R7 model core_rdata", core_rdata, cout[0]);
      chk("R10 model irq_pend", irq_pend, m_pend);
      chk("R11 model irq", irq, m_pend && irq_mask);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [6:0] cw(bit en, bit fl, bit [1:0] mode, bit dir, bit dma, bit intio);
    return {intio, dma, dir, mode, fl, en};
  endfunction

  task automatic ctl(input logic [6:0] d);
    ctrl_wr = 1'b1; ctrl_wdata = d; tick(); ctrl_wr = 1'b0;
  endtask

  task automatic setup(bit [1:0] mode, bit dir, bit dma, bit intio);
    ctl(cw(0, 1, mode, dir, dma, intio));
    ctl(cw(1, 0, mode, dir, dma, intio));
  endtask

  task automatic hw(input logic [31:0] w);
    host_wr = 1'b1; host_wdata = w; tick(); host_wr = 1'b0;
  endtask

  task automatic cwr(input logic [47:0] w);
    core_wr = 1'b1; core_wdata = w; tick(); core_wr = 1'b0;
  endtask

  task automatic cr();
    core_rd = 1'b1; tick(); core_rd = 1'b0;
  endtask

  task automatic hr(input string tag, input logic [31:0] exp);
    chk(tag, host_rdata, exp);
    host_rd = 1'b1; tick(); host_rd = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (5) tick();

    // R1 reset state
    chk("R1 ctrl_rdata", ctrl_rdata, 7'h00);
    chk("R1 host_wready", host_wready, 1'b0);
    chk("R1 core_wready", core_wready, 1'b0);
    chk("R1 rvalid", {host_rvalid, core_rvalid}, 2'b00);
    chk("R1 irq", {irq_pend, irq}, 2'b00);

    // R4 enable and flush together
    ctl(7'h03);
    chk("R4 ctrl_err pulse", ctrl_err, 1'b1);
    chk("R4 enable not stored", ctrl_rdata[0], 1'b0);
    tick();
    chk("R4 ctrl_err single", ctrl_err, 1'b0);

    // R2 readback layout
    ctl(cw(1, 0, 2'b01, 1, 1, 1));
    chk("R2 readback", ctrl_rdata, 7'h75);

    // R5 16-to-32 pack, R9 ignored write
    setup(2'b00, 0, 0, 0);
    hw(32'hAAAA_1234);
    chk("R5 half group not valid", core_rvalid, 1'b0);
    hw(32'h5555_ABCD);
    chk("R5 packed word", core_rdata, 48'h0000_ABCD_1234);
    chk("R9 host not ready while full", host_wready, 1'b0);
    hw(32'hFFFF_9999);
    chk("R9 write ignored", core_rdata, 48'h0000_ABCD_1234);
    cr();
    chk("R9 ready after drain", {core_rvalid, host_wready}, 2'b01);

    // R6 16-to-48 pack
    setup(2'b01, 0, 0, 0);
    hw(32'h0000_1111); hw(32'h0000_2222); hw(32'h0000_3333);
    chk("R6 packed word", core_rdata, 48'h3333_2222_1111);
    cr();

    // R7 32-to-48 pack
    setup(2'b10, 0, 0, 0);
    hw(32'h1111_2222); hw(32'h3333_4444); hw(32'h5555_6666);
    chk("R7 first core word", core_rdata, 48'h4444_1111_2222);
    cr();
    chk("R7 second core word", core_rdata, 48'h5555_6666_3333);
    cr();
    chk("R7 restart ready", host_wready, 1'b1);

    // R8 unpack 32-to-48 and 16-to-32
    setup(2'b10, 1, 0, 0);
    chk("R8 core ready", core_wready, 1'b1);
    cwr(48'hAAAA_BBBB_CCCC);
    chk("R8 half group not valid", host_rvalid, 1'b0);
    cwr(48'h1111_2222_3333);
    hr("R8 host word 0", 32'hBBBB_CCCC);
    hr("R8 host word 1", 32'h3333_AAAA);
    hr("R8 host word 2", 32'h1111_2222);
    chk("R8 drained", host_rvalid, 1'b0);
    setup(2'b00, 1, 0, 0);
    cwr(48'h9999_8765_4321);
    hr("R8 narrow word 0", 32'h0000_4321);
    hr("R8 narrow word 1", 32'h0000_8765);

    // R3 flush discards partial group and takes effect next cycle
    setup(2'b00, 0, 0, 0);
    hw(32'h0000_7777);
    ctl(cw(0, 1, 2'b00, 0, 0, 0));
    chk("R3 flush reads zero", ctrl_rdata[1], 1'b0);
    ctl(cw(1, 0, 2'b00, 0, 0, 0));
    hw(32'h0000_0001); hw(32'h0000_0002);
    chk("R3 partial discarded", core_rdata, 48'h0000_0002_0001);
    ctrl_wr = 1'b1; ctrl_wdata = cw(1, 1, 2'b00, 0, 0, 0);
    #1;
    chk("R3 same-cycle status", core_rvalid, 1'b1);
    @(posedge clk); #1; ctrl_wr = 1'b0;
    chk("R3 next-cycle empty", core_rvalid, 1'b0);

    // R10 / R11 interrupt
    setup(2'b00, 0, 0, 1);
    irq_mask = 1'b0;
    hw(32'h1); hw(32'h2);
    tick();
    chk("R10 latch sets while masked", {irq_pend, irq}, 2'b10);
    irq_mask = 1'b1; #1;
    chk("R11 mask passes", irq, 1'b1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    chk("R11 cleared", irq_pend, 1'b0);
    cr();
    setup(2'b00, 1, 0, 1);
    tick();
    chk("R10 write side empty request", irq_pend, 1'b1);
    setup(2'b00, 1, 1, 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    repeat (3) tick();
    chk("R10 suppressed with DMA enabled", {irq_pend, irq}, 2'b00);

    repeat (2) tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule